// File: doc/BRIEF.md
# Hex Record Stream Loader

This block sits behind a character receiver and turns a stream of ASCII hexadecimal object records into byte writes on a memory port. One character arrives per cycle in which `rx_valid` is high. Each record is parsed field by field, and its checksum is accumulated as the bytes are decoded. Every payload byte of a data record is written as soon as its second digit arrives.

The loader keeps the upper 16 address bits that extended linear address records supply and adds them to each data record's 16-bit offset. It latches a 32-bit entry point from a start linear address record. An end-of-file record raises a sticky `done` flag, and from then on the loader accepts no more input. Checksum, format and record-type problems each set their own sticky flag, so a boot controller can decide afterwards whether the image it loaded can be trusted.

Top module: `hexld_loader`

## Requirements
- R1: While the loader is waiting for a record, every character other than the colon (0x3A) is ignored. Such characters cause no write, change no flag and do not alter the entry point.
- R2: A record consists of a colon followed by fields of two hex digits each: length byte, address high byte, address low byte, type byte, `length` data bytes, then a checksum byte. For type 0x00, data byte k is written to address `(upper << 16) + offset + k`. The write is computed modulo 2^32, and `wr_en` is high for exactly the one cycle after the clock edge that accepts the byte's second digit.
- R3: Hex digits 0-9, A-F and a-f are all accepted, and both letter cases give the same value (parameter `ACCEPT_LOWER`, default 1).
- R4: A type 0x04 record with length 2 and a valid checksum replaces the upper address half with its two data bytes, the first byte being the more significant. The upper half is 0 after reset.
- R5: A type 0x05 record with length 4 and a valid checksum loads `entry_addr` with its four data bytes, the first byte being the most significant. `entry_addr` resets to `ENTRY_RST` (default 0).
- R6: A type 0x01 record with length 0 and a valid checksum sets `done`. `done` stays set until reset, and after it is set all further input is ignored: no writes occur and `entry_addr` does not change.
- R7: A record's checksum is correct when the low 8 bits of the sum of every decoded byte, from the length byte through the checksum byte, are zero. If the sum is not zero, the sticky `err_csum` flag is set and the record's type 0x01/0x04/0x05 effect is suppressed. Writes already issued for a data record stay in place.
- R8: A non-hex character inside a record sets the sticky `err_fmt` flag and returns the loader to waiting for a colon. A colon inside a record also sets `err_fmt`, and that colon starts a new record.
- R9: A record type other than 0x00, 0x01, 0x04 or 0x05 sets the sticky `err_type` flag, and so does a length other than 0, 2 or 4 respectively for types 0x01, 0x04 and 0x05. Such a record produces no write and has no effect.
- R10: Data records of up to at least 16 bytes are written in full, with consecutive addresses.
- R11: After reset, `wr_en`, `done`, `err_csum`, `err_fmt` and `err_type` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | `rx_char` holds a character this cycle |
| rx_char | input | 8 | ASCII character |
| wr_en | output | 1 | Byte write strobe |
| wr_addr | output | 32 | Byte write address |
| wr_data | output | 8 | Byte write data |
| done | output | 1 | End-of-file record accepted (sticky) |
| entry_addr | output | 32 | Entry point from the last valid start record |
| err_csum | output | 1 | Checksum mismatch seen (sticky) |
| err_fmt | output | 1 | Bad character inside a record seen (sticky) |
| err_type | output | 1 | Unknown type or wrong length seen (sticky) |

## Verification
A wrong upper address half or byte index shows up on `wr_addr` at the very next write of a data record. This happens within two characters after the second digit of the faulty byte, so the scoreboard compares every write against an address computed from the record text. A digit-pairing or field-state slip shifts each later byte by a nibble or a field, and the closing checksum then raises `err_csum` at the end of the same record. Mistakes in entry, upper-half or done handling appear on `entry_addr`, on the next data address or on `done` one cycle after the checksum's second digit. Each of these is sampled a few cycles after every record.

// File: rtl/hexld_pkg.sv
package hexld_pkg;
   localparam int HALF_W = 16;
   localparam int ADDR_W = 2 * HALF_W;
   localparam logic [7:0] MARK_CHAR = 8'h3A;
   localparam logic [7:0] REC_DATA  = 8'h00;
   localparam logic [7:0] REC_EOF   = 8'h01;
   localparam logic [7:0] REC_XLIN  = 8'h04;
   localparam logic [7:0] REC_START = 8'h05;

   typedef enum logic [2:0] {
      ST_HUNT, ST_LEN, ST_AHI, ST_ALO, ST_TYPE, ST_DATA, ST_CSUM
   } hexld_state_e;
endpackage

// File: rtl/hexld_digit.sv
module hexld_digit #(
   parameter bit ACCEPT_LOWER = 1'b1
) (
   input  logic [7:0] ch,
   output logic       is_hex,
   output logic       is_mark,
   output logic [3:0] nib
);
   logic num_hit, up_hit, lo_hit;

   assign num_hit = (ch >= 8'h30) && (ch <= 8'h39);
   assign up_hit  = (ch >= 8'h41) && (ch <= 8'h46);

   generate
      if (ACCEPT_LOWER) begin : g_lower
         assign lo_hit = (ch >= 8'h61) && (ch <= 8'h66);
      end else begin : g_upper_only
         assign lo_hit = 1'b0;
      end
   endgenerate

   assign is_hex  = num_hit | up_hit | lo_hit;
   assign is_mark = (ch == hexld_pkg::MARK_CHAR);
   assign nib     = num_hit ? ch[3:0] : (ch[3:0] + 4'd9);
endmodule

// File: rtl/hexld_bytepair.sv
module hexld_bytepair (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       dig_stb,
   input  logic [3:0] nib,
   output logic       byte_stb,
   output logic [7:0] byte_val
);
   logic       second;
   logic [3:0] hi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         second <= 1'b0;
         hi_q   <= '0;
      end else if (clr) begin
         second <= 1'b0;
      end else if (dig_stb) begin
         second <= ~second;
         if (!second) hi_q <= nib;
      end
   end

   assign byte_stb = dig_stb & second & ~clr;
   assign byte_val = {hi_q, nib};
endmodule

// File: rtl/hexld_wrgen.sv
module hexld_wrgen #(
   parameter int HALF_W = 16,
   parameter int CNT_W  = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  fire,
   input  logic [HALF_W-1:0]     upper,
   input  logic [HALF_W-1:0]     offs,
   input  logic [CNT_W-1:0]      idx,
   input  logic [7:0]            din,
   output logic                  wr_en,
   output logic [2*HALF_W-1:0]   wr_addr,
   output logic [7:0]            wr_data
);
   localparam int AW = 2 * HALF_W;
   logic [AW-1:0] target;

   assign target = {upper, {HALF_W{1'b0}}} + AW'(offs) + AW'(idx);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= fire;
         if (fire) begin
            wr_addr <= target;
            wr_data <= din;
         end
      end
   end
endmodule

// File: rtl/hexld_loader.sv
module hexld_loader #(
   parameter bit          ACCEPT_LOWER = 1'b1,
   parameter int          CNT_W        = 8,
   parameter logic [31:0] ENTRY_RST    = 32'h0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rx_valid,
   input  logic [7:0]  rx_char,
   output logic        wr_en,
   output logic [31:0] wr_addr,
   output logic [7:0]  wr_data,
   output logic        done,
   output logic [31:0] entry_addr,
   output logic        err_csum,
   output logic        err_fmt,
   output logic        err_type
);
   import hexld_pkg::*;

   generate
      if (CNT_W < 8) begin : g_bad_cnt
         $error("hexld_loader: CNT_W must cover an 8-bit length");
      end
   endgenerate

   hexld_state_e        state;
   logic [7:0]          len_q, rtype_q, sum_q;
   logic [HALF_W-1:0]   offs_q, upper_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [31:0]         payload_q;

   logic       is_hex, is_mark, take, in_rec, dig_stb, clr, byte_stb, fire;
   logic [3:0] nib;
   logic [7:0] byte_val, final_sum;
   logic       csum_ok, len_ok, known;

   hexld_digit #(.ACCEPT_LOWER(ACCEPT_LOWER)) u_digit (
      .ch(rx_char), .is_hex(is_hex), .is_mark(is_mark), .nib(nib)
   );

   assign take    = rx_valid & ~done;
   assign in_rec  = (state != ST_HUNT);
   assign dig_stb = take & in_rec & is_hex;
   assign clr     = take & (is_mark | (in_rec & ~is_hex));

   hexld_bytepair u_pair (
      .clk(clk), .rst_n(rst_n), .clr(clr), .dig_stb(dig_stb), .nib(nib),
      .byte_stb(byte_stb), .byte_val(byte_val)
   );

   assign fire = byte_stb && (state == ST_DATA) && (rtype_q == REC_DATA);

   hexld_wrgen #(.HALF_W(HALF_W), .CNT_W(CNT_W)) u_wr (
      .clk(clk), .rst_n(rst_n), .fire(fire), .upper(upper_q), .offs(offs_q),
      .idx(cnt_q), .din(byte_val), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data)
   );

   assign final_sum = sum_q + byte_val;
   assign csum_ok   = (final_sum == 8'h00);

   always_comb begin
      known  = 1'b1;
      len_ok = 1'b1;
      unique case (rtype_q)
         REC_DATA:  len_ok = 1'b1;
         REC_EOF:   len_ok = (len_q == 8'd0);
         REC_XLIN:  len_ok = (len_q == 8'd2);
         REC_START: len_ok = (len_q == 8'd4);
         default:   known  = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_HUNT;
         len_q      <= '0;
         rtype_q    <= '0;
         sum_q      <= '0;
         offs_q     <= '0;
         upper_q    <= '0;
         cnt_q      <= '0;
         payload_q  <= '0;
         done       <= 1'b0;
         entry_addr <= ENTRY_RST;
         err_csum   <= 1'b0;
         err_fmt    <= 1'b0;
         err_type   <= 1'b0;
      end else if (take) begin
         if (is_mark) begin
            if (in_rec) err_fmt <= 1'b1;
            state <= ST_LEN;
            sum_q <= '0;
         end else if (in_rec && !is_hex) begin
            err_fmt <= 1'b1;
            state   <= ST_HUNT;
         end else if (byte_stb) begin
            sum_q <= final_sum;
            unique case (state)
               ST_LEN: begin
                  len_q <= byte_val;
                  state <= ST_AHI;
               end
               ST_AHI: begin
                  offs_q[15:8] <= byte_val;
                  state        <= ST_ALO;
               end
               ST_ALO: begin
                  offs_q[7:0] <= byte_val;
                  state       <= ST_TYPE;
               end
               ST_TYPE: begin
                  rtype_q <= byte_val;
                  cnt_q   <= '0;
                  state   <= (len_q == 8'd0) ? ST_CSUM : ST_DATA;
               end
               ST_DATA: begin
                  payload_q <= {payload_q[23:0], byte_val};
                  cnt_q     <= cnt_q + 1'b1;
                  if (cnt_q + 1'b1 == CNT_W'(len_q)) state <= ST_CSUM;
               end
               ST_CSUM: begin
                  state <= ST_HUNT;
                  if (!csum_ok) err_csum <= 1'b1;
                  if (!known || !len_ok) err_type <= 1'b1;
                  if (csum_ok && known && len_ok) begin
                     if (rtype_q == REC_EOF)   done       <= 1'b1;
                     if (rtype_q == REC_XLIN)  upper_q    <= payload_q[15:0];
                     if (rtype_q == REC_START) entry_addr <= payload_q;
                  end
               end
               default: state <= ST_HUNT;
            endcase
         end
      end
   end
endmodule

// File: rtl/hexld_checker.sv
module hexld_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        rx_valid,
   input logic        wr_en,
   input logic        done,
   input logic [31:0] entry_addr,
   input logic        err_csum,
   input logic        err_fmt,
   input logic        err_type
);
   logic armed;

   always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   p_wr_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   p_wr_needs_char_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && wr_en) |-> $past(rx_valid));

   p_entry_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(rx_valid)) |-> $stable(entry_addr));

   p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

   p_no_write_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !wr_en);

   p_csum_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_csum |=> err_csum);

   p_fmt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_fmt |=> err_fmt);

   p_type_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_type |=> err_type);
endmodule

bind hexld_loader hexld_checker u_chk (
   .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .wr_en(wr_en), .done(done),
   .entry_addr(entry_addr), .err_csum(err_csum), .err_fmt(err_fmt),
   .err_type(err_type)
);

// File: tb/sim_hexld_loader.sv
module sim_hexld_loader;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_char = 8'h00;
   logic        wr_en, done, err_csum, err_fmt, err_type;
   logic [31:0] wr_addr, entry_addr;
   logic [7:0]  wr_data;

   int nchk = 0;
   int nfail = 0;
   bit reported = 1'b0;
   logic [39:0] expq[$];
   logic [7:0]  pl [0:31];
   logic [15:0] exp_upper = 16'h0;
   bit          exp_done = 1'b0;

   always #5 clk = ~clk;

   hexld_loader u0 (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done),
      .entry_addr(entry_addr), .err_csum(err_csum), .err_fmt(err_fmt),
      .err_type(err_type)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   endtask

   // scoreboard monitor: every write must match the head of the queue
   always @(negedge clk) begin
      if (rst_n && wr_en) begin
         nchk++;
         if (expq.size() == 0) begin
            nfail++;
            $display("FAIL R2/R9 unexpected write actual=%h:%h expected=none", wr_addr, wr_data);
         end else begin
            logic [39:0] e;
            e = expq.pop_front();
            if ({wr_addr, wr_data} !== e) begin
               nfail++;
               $display("FAIL R2 write actual=%h:%h expected=%h:%h",
                        wr_addr, wr_data, e[39:8], e[7:0]);
            end
         end
      end
   end

   function automatic logic [7:0] hx(input logic [3:0] n, input bit lc);
      if (n < 4'd10) return 8'h30 + {4'h0, n};
      return (lc ? 8'h61 : 8'h41) + {4'h0, n} - 8'd10;
   endfunction

   task automatic send_char(input logic [7:0] c);
      @(negedge clk);
      rx_valid = 1'b1;
      rx_char  = c;
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      rx_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic send_str(input string s);
      for (int i = 0; i < s.len(); i++) send_char(s[i]);
   endtask

   task automatic send_byte(input logic [7:0] b, input bit lc);
      send_char(hx(b[7:4], lc));
      send_char(hx(b[3:0], lc));
   endtask

   // driver: emits one record from pl[] and queues the writes it implies
   task automatic send_rec(input logic [7:0] len, input logic [15:0] a,
                           input logic [7:0] t, input bit lc, input bit bad);
      logic [7:0] s;
      s = len + a[15:8] + a[7:0] + t;
      for (int i = 0; i < len; i++) s = s + pl[i];
      s = 8'h00 - s;
      if (bad) s = s ^ 8'h01;
      if (t == 8'h00 && !exp_done)
         for (int i = 0; i < len; i++)
            expq.push_back({({exp_upper, 16'h0} + {16'h0, a} + 32'(i)), pl[i]});
      send_char(8'h3A);
      send_byte(len, lc);
      send_byte(a[15:8], lc);
      send_byte(a[7:0], lc);
      send_byte(t, lc);
      for (int i = 0; i < len; i++) send_byte(pl[i], lc);
      send_byte(s, lc);
      if (!bad && !exp_done) begin
         if (t == 8'h04 && len == 8'd2) exp_upper = {pl[0], pl[1]};
         if (t == 8'h01 && len == 8'd0) exp_done = 1'b1;
      end
      send_str("\r\n");
      idle(3);
   endtask

   task automatic drained(input string req);
      idle(2);
      chk(req, 32'(expq.size()), 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      chk("R11 wr_en", 32'(wr_en), 0);
      chk("R11 done", 32'(done), 0);
      chk("R11 errs", {29'h0, err_csum, err_fmt, err_type}, 0);
      chk("R5 entry reset", entry_addr, 32'h0);
      rst_n = 1'b1;

      // R1: junk before the mark, then a data record
      send_str("zz 12;");
      idle(2);
      chk("R1 junk no flags", {29'h0, err_csum, err_fmt, err_type}, 0);
      for (int i = 0; i < 4; i++) pl[i] = 8'h11 * (i + 1);
      send_rec(8'd4, 16'h0010, 8'h00, 1'b0, 1'b0);
      drained("R2 data record");

      // R4: extended linear address
      pl[0] = 8'h00; pl[1] = 8'h08;
      send_rec(8'd2, 16'h0000, 8'h04, 1'b0, 1'b0);
      // R3, R10: sixteen bytes in lower-case digits
      for (int i = 0; i < 16; i++) pl[i] = 8'hA0 + 8'(i * 3);
      send_rec(8'd16, 16'h0000, 8'h00, 1'b1, 1'b0);
      drained("R10 sixteen bytes R3 R4");
      chk("R3 no csum error", 32'(err_csum), 0);

      // R2: offset plus index carries into the upper half
      for (int i = 0; i < 4; i++) pl[i] = 8'h5A + 8'(i);
      send_rec(8'd4, 16'hFFFE, 8'h00, 1'b0, 1'b0);
      drained("R2 carry");

      // R5: start linear address
      pl[0] = 8'h12; pl[1] = 8'h34; pl[2] = 8'hAB; pl[3] = 8'hCD;
      send_rec(8'd4, 16'h0000, 8'h05, 1'b0, 1'b0);
      chk("R5 entry", entry_addr, 32'h1234ABCD);

      // R7: bad checksum on extended record leaves upper half alone
      pl[0] = 8'h12; pl[1] = 8'h34;
      send_rec(8'd2, 16'h0000, 8'h04, 1'b0, 1'b1);
      chk("R7 err_csum", 32'(err_csum), 1);
      chk("R7 other flags", {30'h0, err_fmt, err_type}, 0);
      pl[0] = 8'h77;
      send_rec(8'd1, 16'h0003, 8'h00, 1'b0, 1'b0);
      drained("R7 upper kept");
      // R7: bad checksum data record still writes
      pl[0] = 8'hC1; pl[1] = 8'hC2;
      send_rec(8'd2, 16'h0100, 8'h00, 1'b0, 1'b1);
      drained("R7 writes kept");

      // R8: non-hex inside record
      send_str(":02G0");
      idle(3);
      chk("R8 err_fmt", 32'(err_fmt), 1);
      drained("R8 no write");
      // R8: colon inside record restarts
      send_str(":0300");
      pl[0] = 8'h9E;
      send_rec(8'd1, 16'h0040, 8'h00, 1'b0, 1'b0);
      drained("R8 restart write");

      // R9: unknown type and wrong length
      chk("R9 err_type before", 32'(err_type), 0);
      pl[0] = 8'h44;
      send_rec(8'd1, 16'h0050, 8'h07, 1'b0, 1'b0);
      chk("R9 err_type", 32'(err_type), 1);
      drained("R9 no write");
      pl[0] = 8'hEE; pl[1] = 8'hFF;
      send_rec(8'd2, 16'h0000, 8'h05, 1'b0, 1'b0);
      chk("R9 entry unchanged", entry_addr, 32'h1234ABCD);

      // R6: end of file, then input ignored
      chk("R6 done before", 32'(done), 0);
      send_rec(8'd0, 16'h0000, 8'h01, 1'b0, 1'b0);
      chk("R6 done", 32'(done), 1);
      pl[0] = 8'h01; pl[1] = 8'h02; pl[2] = 8'h03; pl[3] = 8'h04;
      send_rec(8'd4, 16'h0000, 8'h05, 1'b0, 1'b0);
      send_rec(8'd2, 16'h0200, 8'h00, 1'b0, 1'b0);
      drained("R6 no write after done");
      chk("R6 entry frozen", entry_addr, 32'h1234ABCD);
      chk("R6 done held", 32'(done), 1);

      report();
   end
endmodule